// File: doc/BRIEF.md
# Dual-group skewed-sampling ADC controller

This block runs one conversion cycle of an eight-channel simultaneous-sampling converter from the host side. The converter's channels are split into two groups, and each group has its own conversion-start strobe. A group is sampled on the rising edge of its strobe. The converter starts converting only once both groups have been sampled. The controller raises the two strobes with a programmable skew between them, counted in system clocks. This lets the sampling instants of two sensing paths with different delays, such as voltage and current, be lined up. Either group may lead, and a skew of zero raises both strobes together.

Once both strobes have been issued and returned low, the controller waits for the converter's busy line to rise and then fall. Each of these two waits has its own timeout. It then reads the eight results over a parallel bus with one chip-select/read low pulse per channel. Each word is captured on the rising edge of the read strobe. It is presented with a 3-bit channel index and a one-clock valid pulse. The converter's first-channel flag is checked on every word.

A skewed start is only legal when the converter is not oversampling. A request that combines a nonzero skew with a nonzero oversampling setting is refused and an error is flagged.

Top module: `skew_adc_ctrl`

## Requirements
- R1: After reset, both start strobes are low, `cs_n` and `rd_n` are high, and `res_valid`, `err_os`, `err_timeout` and `err_frst` are all low.
- R2: A start that is accepted on a clock edge makes the leading strobe rise on the next edge. The leading strobe stays high for HOLD_CLKS clocks. The following strobe rises `skew` clocks after the leading one and also stays high for HOLD_CLKS clocks. With `b_leads` = 0 strobe A leads, and with `b_leads` = 1 strobe B leads. A skew of 0 raises both strobes on the same edge.
- R3: `start` is ignored while a cycle is in progress. No extra strobe edge is produced and the cycle in progress completes unchanged.
- R4: If `start` arrives while the block is idle with `os_mode` nonzero and `skew` nonzero, no strobe is raised and `err_os` pulses for one clock on the following edge. When `os_mode` is nonzero and `skew` is zero, the cycle runs normally.
- R5: No read pulse is issued while either strobe is high. Readout starts only after busy has been seen high and has then fallen.
- R6: If busy is not seen high within BUSY_RISE_WIN clocks after both strobes have returned low, `err_timeout` pulses for one clock. The block then returns to idle with no read pulse.
- R7: If busy stays high for CONV_MAX_CLKS clocks, `err_timeout` pulses for one clock. The block then returns to idle with no read pulse.
- R8: Readout consists of NCH low pulses on `cs_n`/`rd_n` together. Each pulse is low for RD_LOW_CLKS clocks, with RD_HIGH_CLKS high clocks between pulses. `db_i` is captured on the edge where `rd_n` rises, and `res_valid` is high for exactly that clock. `res_chan` counts 0 to NCH-1 in order, where index 0 is channel 1.
- R9: `err_frst` pulses together with `res_valid` when `frst_i` is low on the word with index 0, or high on any word with a later index. On every other word it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion cycle (acted on while idle) |
| skew | input | SKEW_W | Clocks between the leading and following strobe rise |
| b_leads | input | 1 | 0: strobe A leads, 1: strobe B leads |
| os_mode | input | 3 | Converter oversampling setting, 0 means off |
| conv_a | output | 1 | Start strobe for channel group 1 to 4 |
| conv_b | output | 1 | Start strobe for channel group 5 to 8 |
| busy_i | input | 1 | Converter busy line (asynchronous, synchronized inside) |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| db_i | input | DATA_W | Parallel data bus |
| frst_i | input | 1 | First-channel flag from the converter |
| res_valid | output | 1 | One-clock pulse marking a captured word |
| res_data | output | DATA_W | Captured word |
| res_chan | output | CH_W | Channel index of the captured word |
| err_os | output | 1 | Pulse: skewed start refused because oversampling is on |
| err_timeout | output | 1 | Pulse: busy did not rise in time, or stayed high too long |
| err_frst | output | 1 | Pulse: first-channel flag missing or misplaced |

## Verification
The bench builds the block with a 4-bit skew, HOLD_CLKS = 3, BUSY_RISE_WIN = 16, CONV_MAX_CLKS = 40 and two-clock read phases. With these values the largest skew of 15 and both timeouts are reached in a few dozen cycles. The two-stage busy synchronizer is kept, so the conversion handshake runs with its real latency. A behavioural converter model answers the strobes and read pulses, and the strobe levels are compared with a reference computed from the skew, the lead select and the launch cycle on every clock. Faults are injected for a missing busy, a stuck busy and misplaced first-channel flags.

// File: rtl/skew_adc_pkg.sv
package skew_adc_pkg;

   // sequencing state of the controller
   typedef enum logic [1:0] {
      CT_IDLE   = 2'd0,
      CT_STROBE = 2'd1,
      CT_CONV   = 2'd2,
      CT_READ   = 2'd3
   } ctl_state_t;

   // busy watcher state
   typedef enum logic [1:0] {
      BM_IDLE = 2'd0,
      BM_RISE = 2'd1,
      BM_HIGH = 2'd2
   } bmon_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/skew_strobe_gen.sv
module skew_strobe_gen #(
   parameter int SKEW_W    = 8,
   parameter int HOLD_CLKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [SKEW_W-1:0] skew,
   input  logic              b_leads,
   output logic              conv_a,
   output logic              conv_b,
   output logic              done
);
   localparam int CW = SKEW_W + $clog2(HOLD_CLKS + 1) + 1;
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CLKS);

   logic              active;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     skew_q;
   logic              b_lead_q;
   logic [CW-1:0]     last_cnt;
   logic              lead_on;
   logic              follow_on;

   // one counter spans both windows; the follower window is offset by skew
   always_comb begin
      last_cnt  = skew_q + HOLD_C - CW'(1);
      lead_on   = active && (cnt < HOLD_C);
      follow_on = active && (cnt >= skew_q) && (cnt < (skew_q + HOLD_C));
      done      = active && (cnt == last_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cnt      <= '0;
         skew_q   <= '0;
         b_lead_q <= 1'b0;
      end else if (launch) begin
         active   <= 1'b1;
         cnt      <= '0;
         skew_q   <= CW'(skew);
         b_lead_q <= b_leads;
      end else if (active) begin
         if (cnt == last_cnt) begin
            active <= 1'b0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // strobes leave through flops so the pins never glitch on decode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_a <= 1'b0;
         conv_b <= 1'b0;
      end else begin
         conv_a <= b_lead_q ? follow_on : lead_on;
         conv_b <= b_lead_q ? lead_on   : follow_on;
      end
   end

endmodule

// File: rtl/skew_busy_monitor.sv
module skew_busy_monitor
   import skew_adc_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int BUSY_RISE_WIN = 64,
   parameter int CONV_MAX_CLKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic busy_i,
   output logic done,
   output logic tmo_now,
   output logic err_timeout
);
   localparam int MW = $clog2(max2(BUSY_RISE_WIN, CONV_MAX_CLKS) + 1);
   localparam logic [MW-1:0] RISE_LAST = MW'(BUSY_RISE_WIN - 1);
   localparam logic [MW-1:0] CONV_LAST = MW'(CONV_MAX_CLKS - 1);

   logic        busy_s;
   bmon_state_t st;
   logic [MW-1:0] cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign busy_s = busy_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[SYNC_STAGES-2:0], busy_i};
         end
         assign busy_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      done    = (st == BM_HIGH) && !busy_s;
      tmo_now = ((st == BM_RISE) && !busy_s && (cnt == RISE_LAST)) ||
                ((st == BM_HIGH) &&  busy_s && (cnt == CONV_LAST));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= BM_IDLE;
         cnt         <= '0;
         err_timeout <= 1'b0;
      end else begin
         err_timeout <= tmo_now;
         unique case (st)
            BM_IDLE: begin
               if (arm) begin
                  st  <= BM_RISE;
                  cnt <= '0;
               end
            end
            BM_RISE: begin
               if (busy_s) begin
                  st  <= BM_HIGH;
                  cnt <= '0;
               end else if (tmo_now) begin
                  st <= BM_IDLE;
               end else begin
                  cnt <= cnt + MW'(1);
               end
            end
            BM_HIGH: begin
               if (done || tmo_now) st  <= BM_IDLE;
               else                 cnt <= cnt + MW'(1);
            end
            default: st <= BM_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/skew_adc_readout.sv
module skew_adc_readout
   import skew_adc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int NCH          = 8,
   parameter int RD_LOW_CLKS  = 2,
   parameter int RD_HIGH_CLKS = 2,
   localparam int CH_W        = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [DATA_W-1:0] db_i,
   input  logic              frst_i,
   output logic              cs_n,
   output logic              rd_n,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CH_W-1:0]   res_chan,
   output logic              err_frst,
   output logic              done
);
   localparam int PW = $clog2(max2(RD_LOW_CLKS, RD_HIGH_CLKS) + 1);
   localparam logic [PW-1:0]   LOW_LAST  = PW'(RD_LOW_CLKS - 1);
   localparam logic [PW-1:0]   HIGH_LAST = PW'(RD_HIGH_CLKS - 1);
   localparam logic [CH_W-1:0] CH_LAST   = CH_W'(NCH - 1);

   logic            active;
   logic            low_ph;
   logic [PW-1:0]   pc;
   logic [CH_W-1:0] ch;
   logic            strobe_q;
   logic            capture;

   always_comb begin
      capture = active && low_ph && (pc == LOW_LAST);
      done    = capture && (ch == CH_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         low_ph    <= 1'b0;
         pc        <= '0;
         ch        <= '0;
         strobe_q  <= 1'b0;
         res_valid <= 1'b0;
         res_data  <= '0;
         res_chan  <= '0;
         err_frst  <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         err_frst  <= 1'b0;
         if (go && !active) begin
            active   <= 1'b1;
            low_ph   <= 1'b1;
            pc       <= '0;
            ch       <= '0;
            strobe_q <= 1'b1;
         end else if (active) begin
            if (low_ph) begin
               if (capture) begin
                  // word taken on the same edge that lifts the read strobe
                  strobe_q  <= 1'b0;
                  low_ph    <= 1'b0;
                  pc        <= '0;
                  res_valid <= 1'b1;
                  res_data  <= db_i;
                  res_chan  <= ch;
                  err_frst  <= (ch == '0) ? !frst_i : frst_i;
                  if (ch == CH_LAST) active <= 1'b0;
               end else begin
                  pc <= pc + PW'(1);
               end
            end else if (pc == HIGH_LAST) begin
               strobe_q <= 1'b1;
               low_ph   <= 1'b1;
               pc       <= '0;
               ch       <= ch + CH_W'(1);
            end else begin
               pc <= pc + PW'(1);
            end
         end
      end
   end

   assign rd_n = !strobe_q;
   assign cs_n = !strobe_q;

endmodule

// File: rtl/skew_adc_ctrl.sv
module skew_adc_ctrl
   import skew_adc_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int NCH           = 8,
   parameter int SKEW_W        = 8,
   parameter int HOLD_CLKS     = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int BUSY_RISE_WIN = 64,
   parameter int CONV_MAX_CLKS = 1000,
   parameter int RD_LOW_CLKS   = 2,
   parameter int RD_HIGH_CLKS  = 2,
   localparam int CH_W         = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SKEW_W-1:0] skew,
   input  logic              b_leads,
   input  logic [2:0]        os_mode,
   output logic              conv_a,
   output logic              conv_b,
   input  logic              busy_i,
   output logic              cs_n,
   output logic              rd_n,
   input  logic [DATA_W-1:0] db_i,
   input  logic              frst_i,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CH_W-1:0]   res_chan,
   output logic              err_os,
   output logic              err_timeout,
   output logic              err_frst
);
   // elaboration-time parameter checks
   generate
      if (NCH < 2 || (1 << CH_W) != NCH) begin : g_bad_nch
         $error("NCH must be a power of two, at least 2");
      end
      if (HOLD_CLKS < 2) begin : g_bad_hold
         $error("HOLD_CLKS must be at least 2");
      end
      if (SKEW_W < 1) begin : g_bad_skew
         $error("SKEW_W must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
      if (BUSY_RISE_WIN < 1 || CONV_MAX_CLKS < 1) begin : g_bad_win
         $error("busy windows must be at least one clock");
      end
      if (RD_LOW_CLKS < 1 || RD_HIGH_CLKS < 1) begin : g_bad_rd
         $error("read phases must be at least one clock");
      end
   endgenerate

   ctl_state_t st;
   logic os_block;
   logic launch;
   logic sg_done;
   logic mon_done;
   logic mon_tmo;
   logic rd_done;

   always_comb begin
      os_block = (os_mode != 3'd0) && (skew != '0);
      launch   = start && (st == CT_IDLE) && !os_block;
   end

   skew_strobe_gen #(
      .SKEW_W    (SKEW_W),
      .HOLD_CLKS (HOLD_CLKS)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .skew    (skew),
      .b_leads (b_leads),
      .conv_a  (conv_a),
      .conv_b  (conv_b),
      .done    (sg_done)
   );

   skew_busy_monitor #(
      .SYNC_STAGES   (SYNC_STAGES),
      .BUSY_RISE_WIN (BUSY_RISE_WIN),
      .CONV_MAX_CLKS (CONV_MAX_CLKS)
   ) u_busy (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (sg_done),
      .busy_i      (busy_i),
      .done        (mon_done),
      .tmo_now     (mon_tmo),
      .err_timeout (err_timeout)
   );

   skew_adc_readout #(
      .DATA_W       (DATA_W),
      .NCH          (NCH),
      .RD_LOW_CLKS  (RD_LOW_CLKS),
      .RD_HIGH_CLKS (RD_HIGH_CLKS)
   ) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (mon_done && (st == CT_CONV)),
      .db_i      (db_i),
      .frst_i    (frst_i),
      .cs_n      (cs_n),
      .rd_n      (rd_n),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_chan  (res_chan),
      .err_frst  (err_frst),
      .done      (rd_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CT_IDLE;
         err_os <= 1'b0;
      end else begin
         err_os <= start && (st == CT_IDLE) && os_block;
         unique case (st)
            CT_IDLE:   if (launch)   st <= CT_STROBE;
            CT_STROBE: if (sg_done)  st <= CT_CONV;
            CT_CONV: begin
               if (mon_done)     st <= CT_READ;
               else if (mon_tmo) st <= CT_IDLE;
            end
            CT_READ:   if (rd_done)  st <= CT_IDLE;
            default:   st <= CT_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/skew_adc_ctrl_chk.sv
module skew_adc_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic conv_a,
   input logic conv_b,
   input logic rd_n,
   input logic res_valid,
   input logic err_os,
   input logic err_timeout,
   input logic err_frst
);
   // R5
   read_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!conv_a && !conv_b));

   // R4
   os_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_os |=> (!conv_a && !conv_b));

   // R2
   hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_a) |=> conv_a);

   // R2
   hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_b) |=> conv_b);

   // R8
   capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(rd_n));

   // R9
   frst_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_frst |-> res_valid);

   // R6
   timeout_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> (rd_n && !res_valid));

endmodule

bind skew_adc_ctrl skew_adc_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_a      (conv_a),
   .conv_b      (conv_b),
   .rd_n        (rd_n),
   .res_valid   (res_valid),
   .err_os      (err_os),
   .err_timeout (err_timeout),
   .err_frst    (err_frst)
);

// File: tb/skew_adc_ctrl_bench.sv
`timescale 1ns/1ps
module skew_adc_ctrl_bench;
   localparam int DW    = 16;
   localparam int SKW   = 4;
   localparam int HOLD  = 3;
   localparam int RWIN  = 16;
   localparam int CMAX  = 40;
   localparam int RLOW  = 2;
   localparam int BUSYC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [SKW-1:0] skew = '0;
   logic          b_leads = 1'b0;
   logic [2:0]    os_mode = 3'd0;
   logic          conv_a, conv_b;
   logic          busy_i = 1'b0;
   logic          cs_n, rd_n;
   logic [DW-1:0] db_i = '0;
   logic          frst_i = 1'b0;
   logic          res_valid;
   logic [DW-1:0] res_data;
   logic [2:0]    res_chan;
   logic          err_os, err_timeout, err_frst;

   always #10 clk = ~clk;

   skew_adc_ctrl #(
      .DATA_W(DW), .NCH(8), .SKEW_W(SKW), .HOLD_CLKS(HOLD), .SYNC_STAGES(2),
      .BUSY_RISE_WIN(RWIN), .CONV_MAX_CLKS(CMAX), .RD_LOW_CLKS(RLOW), .RD_HIGH_CLKS(2)
   ) u_skew_adc_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .skew(skew), .b_leads(b_leads),
      .os_mode(os_mode), .conv_a(conv_a), .conv_b(conv_b), .busy_i(busy_i),
      .cs_n(cs_n), .rd_n(rd_n), .db_i(db_i), .frst_i(frst_i),
      .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
      .err_os(err_os), .err_timeout(err_timeout), .err_frst(err_frst)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // reference and converter model state
   int  launch_e = -1000;
   int  m_skew = 0;
   bit  m_bl = 0;
   bit  m_rej = 1;
   int  bmode = 0;      // 0 normal, 1 never busy, 2 stuck busy
   int  fmode = 0;      // 0 good flag, 1 flag missing on word 0, 2 extra flag on word 3
   bit  release_req = 0;
   bit  a_seen = 0, b_seen = 0, armed = 0;
   bit  pa = 0, pb = 0;
   int  bdly = -1;
   int  bhold = 0;
   bit  allow_read = 0;
   bit  prev_rd = 1;
   int  lowlen = 0;
   int  rd_idx = 0;
   int  vcount = 0;
   int  os_cnt = 0;
   int  tmo_cnt = 0;
   int  frst_cnt = 0;
   int  run_id = 0;
   int  exp_q[$];

   always @(negedge clk) begin
      if (rst_n) begin
         int  k;
         bit  lead, foll, ea, eb;
         k  = cyc - launch_e;
         ea = 1'b0;
         eb = 1'b0;
         if (!m_rej) begin
            lead = (k >= 1) && (k <= HOLD);
            foll = (k >= m_skew + 1) && (k <= m_skew + HOLD);
            ea = m_bl ? foll : lead;
            eb = m_bl ? lead : foll;
         end
         chk(conv_a == ea, "R2 strobe A level", conv_a, ea);
         chk(conv_b == eb, "R2 strobe B level", conv_b, eb);

         // converter: conversion only once both groups have been sampled
         if (conv_a && !pa) a_seen = 1;
         if (conv_b && !pb) b_seen = 1;
         pa = conv_a;
         pb = conv_b;
         if (a_seen && b_seen && !armed) begin
            armed = 1;
            if (bmode != 1) bdly = 2;
         end
         if (bdly > 0) bdly--;
         else if (bdly == 0) begin
            busy_i = 1'b1;
            bhold  = (bmode == 2) ? 1000000 : BUSYC;
            bdly   = -1;
         end else if (busy_i) begin
            bhold--;
            if (bhold <= 0 || release_req) begin
               busy_i = 1'b0;
               if (!release_req) allow_read = 1;
            end
         end

         // read bus
         if (!rd_n) chk(allow_read, "R5 read before busy fell", 1, 0);
         chk(cs_n == rd_n, "R8 cs_n with rd_n", cs_n, rd_n);
         if (rd_n && !prev_rd) chk(lowlen == RLOW, "R8 read low width", lowlen, RLOW);
         if (!rd_n) lowlen++;
         else       lowlen = 0;
         if (!rd_n && prev_rd) begin
            db_i   = {4'hC, run_id[7:0], rd_idx[3:0]};
            frst_i = ((rd_idx == 0) && (fmode != 1)) || ((rd_idx == 3) && (fmode == 2));
            exp_q.push_back(int'({4'hC, run_id[7:0], rd_idx[3:0]}));
            rd_idx++;
         end
         prev_rd = rd_n;

         if (res_valid) begin
            int  ew;
            bit  ef;
            ew = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            ef = ((vcount == 0) && (fmode == 1)) || ((vcount == 3) && (fmode == 2));
            chk(int'(res_data) == ew, "R8 word data", res_data, ew);
            chk(int'(res_chan) == vcount, "R8 channel index", res_chan, vcount);
            chk(err_frst == ef, "R9 first-channel check", err_frst, ef);
            vcount++;
         end else if (err_frst) begin
            chk(0, "R9 flag error without word", 1, 0);
         end
         if (err_frst)    frst_cnt++;
         if (err_os)      os_cnt++;
         if (err_timeout) tmo_cnt++;
      end
   end

   task automatic run_cycle(input int sk, input bit bl, input int os, input int bm,
                            input int fm, input bit rej, input bit extra);
      int os0, tmo0, frst0;
      @(negedge clk);
      run_id++;
      a_seen = 0; b_seen = 0; armed = 0; bdly = -1; allow_read = 0;
      release_req = 0; rd_idx = 0; vcount = 0; exp_q.delete();
      bmode = bm; fmode = fm;
      os0 = os_cnt; tmo0 = tmo_cnt; frst0 = frst_cnt;
      skew = SKW'(sk); b_leads = bl; os_mode = 3'(os);
      m_skew = sk; m_bl = bl; m_rej = rej;
      start = 1'b1;
      launch_e = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      if (extra) begin
         repeat (5) @(negedge clk);
         start = 1'b1;      // R3: must be ignored mid-cycle
         @(negedge clk);
         start = 1'b0;
      end
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (vcount == 8) break;
         if (tmo_cnt != tmo0) break;
         if (rej && i > 30) break;
      end
      if (bm == 2) release_req = 1;
      repeat (12) @(negedge clk);
      if (rej) begin
         chk(os_cnt == os0 + 1, "R4 err_os pulse on refused start", os_cnt - os0, 1);
         chk(vcount == 0, "R4 no readout on refused start", vcount, 0);
      end else if (bm != 0) begin
         chk(tmo_cnt == tmo0 + 1, (bm == 1) ? "R6 busy rise timeout" : "R7 busy high timeout",
             tmo_cnt - tmo0, 1);
         chk(vcount == 0, (bm == 1) ? "R6 no readout" : "R7 no readout", vcount, 0);
      end else begin
         chk(vcount == 8, extra ? "R3 cycle completes with stray start" : "R8 eight words",
             vcount, 8);
         chk(tmo_cnt == tmo0, "R6 no timeout on normal cycle", tmo_cnt - tmo0, 0);
         chk(os_cnt == os0, "R4 no err_os on legal start", os_cnt - os0, 0);
         chk(frst_cnt - frst0 == ((fm == 0) ? 0 : 1), "R9 flag error count",
             frst_cnt - frst0, (fm == 0) ? 0 : 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(conv_a == 0 && conv_b == 0, "R1 strobes low in reset", {conv_a, conv_b}, 0);
      chk(cs_n == 1 && rd_n == 1, "R1 bus idle in reset", {cs_n, rd_n}, 3);
      chk(res_valid == 0, "R1 no valid in reset", res_valid, 0);
      chk({err_os, err_timeout, err_frst} == 3'b000, "R1 errors clear in reset",
          {err_os, err_timeout, err_frst}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      run_cycle(5,  1'b0, 0, 0, 0, 1'b0, 1'b0);   // R2 A leads
      run_cycle(4,  1'b1, 0, 0, 0, 1'b0, 1'b0);   // R2 B leads
      run_cycle(0,  1'b0, 0, 0, 0, 1'b0, 1'b0);   // R2 zero skew
      run_cycle(15, 1'b1, 0, 0, 0, 1'b0, 1'b0);   // R2 largest skew
      run_cycle(5,  1'b0, 0, 0, 0, 1'b0, 1'b1);   // R3 stray start
      run_cycle(2,  1'b0, 3, 0, 0, 1'b1, 1'b0);   // R4 refused
      run_cycle(0,  1'b1, 3, 0, 0, 1'b0, 1'b0);   // R4 oversampling, no skew
      run_cycle(3,  1'b0, 0, 0, 1, 1'b0, 1'b0);   // R9 missing flag
      run_cycle(3,  1'b1, 0, 0, 2, 1'b0, 1'b0);   // R9 late flag
      run_cycle(6,  1'b0, 0, 1, 0, 1'b0, 1'b0);   // R6 busy never rises
      run_cycle(1,  1'b1, 0, 2, 0, 1'b0, 1'b0);   // R7 busy stuck
      run_cycle(7,  1'b0, 0, 0, 0, 1'b0, 1'b0);   // recovers after faults

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule